// File: doc/BRIEF.md
# Vector New-Value Producer Resolver

This block sits in the decode path of a wide-issue processor. It takes one decoded packet of up to four instructions per transfer. A vector store can take as its data a value that an earlier vector instruction in the same packet is still producing. The register field of such a store does not name a register. It holds a relative pointer: the upper bits give a backward count of vector instructions, and bit 0 picks the odd or even half of a register pair. For every such consumer, the block finds the producer, replaces the pointer with a real register number, and returns the producer's issue slot. Later stages use that slot to cancel the store when its producer is cancelled. An encoding that cannot be resolved raises an error for that instruction.

Packets come in over a valid/ready handshake and results leave over a second one, with a single register stage between them. A packet is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` one cycle later. The result stays unchanged until a clock edge where `out_ready` is high. While the output register holds a result that is not taken, `in_ready` is low, so back-pressure reaches the producer of packets without delay.

Top module: `vec_newval_resolver`

## Requirements
- R1: Instruction i is a consumer only when i < `in_len` and its vector, store and new-value flags are all set. A non-consumer outputs cons 0, register 0, slot 0 and error 0.
- R2: The N-field of a consumer is 3 bits wide. Bits [2:1] are the backward distance, and bit 0 is the pair select.
- R3: The search walks backward from index i-1 toward index 0 and counts only instructions with the vector flag set. Scalar instructions in between do not reduce the distance.
- R4: When the producer has a destination register, the output register is that destination with its bit 0 XORed with the pair select.
- R5: When the producer has no destination register and has the gather flag set, the output register is the pair select alone, zero-extended.
- R6: When the producer has no destination register and no gather flag, the consumer's error bit is set.
- R7: A distance of zero, or a distance that runs out of vector instructions before reaching index 0, sets the consumer's error bit. A consumer at index 0 is therefore always in error.
- R8: For a consumer without error, the slot output is the producer's `in_slot` value, not its packet index.
- R9: A consumer in error outputs register 0 and slot 0.
- R10: A result appears one cycle after acceptance. While `out_valid` is high and `out_ready` is low, the outputs hold steady. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R11: `out_any_err` is the OR of the per-instruction error bits of the same result.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Packet present |
| in_ready | output | 1 | Packet can be taken |
| in_len | input | 3 | Number of instructions in the packet (0..4) |
| in_vec | input | 4 | Per instruction: vector class |
| in_store | input | 4 | Per instruction: store |
| in_new | input | 4 | Per instruction: uses a new value |
| in_gather | input | 4 | Per instruction: gather |
| in_hasdst | input | 4 | Per instruction: has a destination register |
| in_nfld | input | 12 | Per instruction N-field, 3 bits each, instruction i at [3i+2:3i] |
| in_dst | input | 20 | Per instruction destination register, 5 bits each |
| in_slot | input | 8 | Per instruction issue slot, 2 bits each |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_cons | output | 4 | Per instruction: resolved as consumer |
| out_reg | output | 20 | Per instruction patched register, 5 bits each |
| out_pslot | output | 8 | Per instruction producer slot, 2 bits each |
| out_err | output | 4 | Per instruction encoding error |
| out_any_err | output | 1 | Any error in the packet |

## Verification
Directed packets test the cases one at a time. These include store variants that lack one of the three flags, consumers past `in_len`, one- and two-step distances with scalar instructions in between, gather producers with and without a destination, producers without a destination that are not gathers, a zero distance, a distance that runs past index 0, and a consumer at index 0. Each of these separates one branch of the resolution from the others. A stream of random packets follows, checked against a model in the bench, with `out_ready` pulled low at random. It mixes consumers that serve as producers for later consumers. Its stall cycles show whether results hold steady and keep their order under back-pressure.

// File: rtl/nvr_pkg.sv
package nvr_pkg;
  // Outcome of resolving one instruction position
  typedef enum logic [1:0] {
    RES_NONE   = 2'd0,
    RES_NORMAL = 2'd1,
    RES_GATHER = 2'd2,
    RES_FAULT  = 2'd3
  } res_kind_e;
endpackage

// File: rtl/nvr_scan.sv
// Backward search for the producing vector instruction of lane LANE.
module nvr_scan #(
  parameter int NI   = 4,
  parameter int LANE = 1,
  parameter int DW   = 2,
  localparam int IW  = (NI > 1) ? $clog2(NI) : 1
) (
  input  logic [NI-1:0] vec_i,
  input  logic [DW-1:0] dist_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic          dist_zero_o
);
  logic [DW-1:0] remain;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    remain  = dist_i;
    for (int j = NI - 1; j >= 0; j--) begin
      // only positions earlier than this lane take part (R3)
      if (j < LANE && vec_i[j] && !found_o && remain != '0) begin
        if (remain == DW'(1)) begin
          found_o = 1'b1;
          idx_o   = IW'(j);
        end
        remain = remain - DW'(1);
      end
    end
    dist_zero_o = (dist_i == '0);
  end
endmodule

// File: rtl/nvr_patch.sv
// Computes the patched register and fault for one lane from its producer.
module nvr_patch #(
  parameter int RW = 5
) (
  input  logic               consumer_i,
  input  logic               found_i,
  input  logic               dist_zero_i,
  input  logic               prod_hasdst_i,
  input  logic               prod_gather_i,
  input  logic [RW-1:0]      prod_dst_i,
  input  logic               pair_sel_i,
  output nvr_pkg::res_kind_e kind_o,
  output logic [RW-1:0]      reg_o
);
  import nvr_pkg::*;

  always_comb begin
    if (!consumer_i) begin
      kind_o = RES_NONE;
    end else if (dist_zero_i || !found_i) begin
      kind_o = RES_FAULT;
    end else if (prod_hasdst_i) begin
      kind_o = RES_NORMAL;
    end else if (prod_gather_i) begin
      kind_o = RES_GATHER;
    end else begin
      kind_o = RES_FAULT;
    end

    unique case (kind_o)
      RES_NORMAL: reg_o = prod_dst_i ^ RW'(pair_sel_i);
      RES_GATHER: reg_o = RW'(pair_sel_i);
      default:    reg_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_newval_resolver.sv
module vec_newval_resolver #(
  parameter int NI  = 4,
  parameter int NFW = 3,
  parameter int RW  = 5,
  parameter int SW  = 2,
  localparam int LW = $clog2(NI + 1),
  localparam int IW = (NI > 1) ? $clog2(NI) : 1,
  localparam int DW = NFW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LW-1:0]    in_len,
  input  logic [NI-1:0]    in_vec,
  input  logic [NI-1:0]    in_store,
  input  logic [NI-1:0]    in_new,
  input  logic [NI-1:0]    in_gather,
  input  logic [NI-1:0]    in_hasdst,
  input  logic [NI*NFW-1:0] in_nfld,
  input  logic [NI*RW-1:0] in_dst,
  input  logic [NI*SW-1:0] in_slot,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NI-1:0]    out_cons,
  output logic [NI*RW-1:0] out_reg,
  output logic [NI*SW-1:0] out_pslot,
  output logic [NI-1:0]    out_err,
  output logic             out_any_err
);
  import nvr_pkg::*;

  logic [NI-1:0]    nx_cons;
  logic [NI*RW-1:0] nx_reg;
  logic [NI*SW-1:0] nx_pslot;
  logic [NI-1:0]    nx_err;

  for (genvar g = 0; g < NI; g++) begin : g_lane
    logic          in_range, consumer, found, dzero;
    logic [IW-1:0] pidx;
    res_kind_e     kind;
    logic [RW-1:0] preg;

    assign in_range = (LW'(g) < in_len);
    assign consumer = in_range && in_vec[g] && in_store[g] && in_new[g];

    nvr_scan #(.NI(NI), .LANE(g), .DW(DW)) u_scan (
      .vec_i       (in_vec),
      .dist_i      (in_nfld[g*NFW+1 +: DW]),
      .found_o     (found),
      .idx_o       (pidx),
      .dist_zero_o (dzero)
    );

    nvr_patch #(.RW(RW)) u_patch (
      .consumer_i    (consumer),
      .found_i       (found),
      .dist_zero_i   (dzero),
      .prod_hasdst_i (in_hasdst[pidx]),
      .prod_gather_i (in_gather[pidx]),
      .prod_dst_i    (in_dst[int'(pidx)*RW +: RW]),
      .pair_sel_i    (in_nfld[g*NFW]),
      .kind_o        (kind),
      .reg_o         (preg)
    );

    assign nx_cons[g]             = consumer;
    assign nx_err[g]              = (kind == RES_FAULT);
    assign nx_reg[g*RW +: RW]     = preg;
    assign nx_pslot[g*SW +: SW]   = (kind == RES_NORMAL || kind == RES_GATHER)
                                    ? in_slot[int'(pidx)*SW +: SW] : '0;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_cons    <= '0;
      out_reg     <= '0;
      out_pslot   <= '0;
      out_err     <= '0;
      out_any_err <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cons    <= nx_cons;
        out_reg     <= nx_reg;
        out_pslot   <= nx_pslot;
        out_err     <= nx_err;
        out_any_err <= |nx_err;
      end
    end
  end

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reg) &&
      $stable(out_pslot) && $stable(out_err) && $stable(out_cons)));

  // R10
  ready_only_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R6
  err_needs_consumer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_err & ~out_cons) == '0));

  // R7
  lane0_consumer_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cons[0]) |-> out_err[0]);

  // R9
  err_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err[NI-1]) |->
      (out_reg[(NI-1)*RW +: RW] == '0 && out_pslot[(NI-1)*SW +: SW] == '0));

  // R11
  any_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_any_err == (out_err != '0)));
endmodule

// File: tb/vec_newval_resolver_tb.sv
`timescale 1ns/100ps
module vec_newval_resolver_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid, out_any_err;
  logic [2:0]  in_len = 0;
  logic [3:0]  in_vec = 0, in_store = 0, in_new = 0, in_gather = 0, in_hasdst = 0;
  logic [11:0] in_nfld = 0;
  logic [19:0] in_dst = 0;
  logic [7:0]  in_slot = 0;
  logic [3:0]  out_cons, out_err;
  logic [19:0] out_reg;
  logic [7:0]  out_pslot;

  vec_newval_resolver u_dut (.*);

  typedef struct packed {
    logic vec, st, nw, ga, hd;
    logic [2:0] nf;
    logic [4:0] dst;
    logic [1:0] slot;
  } ins_t;

  typedef struct packed {
    logic [3:0]  cons;
    logic [19:0] rg;
    logic [7:0]  ps;
    logic [3:0]  err;
    logic        any;
    logic [15:0] tag;
  } exp_t;

  ins_t pk [4];
  int   plen;
  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   bp_en = 0, done = 0;

  task automatic chk(input bit ok, input int tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model from the requirements
  function automatic exp_t model();
    exp_t e = '0;
    for (int i = 0; i < 4; i++) begin
      int rem, fnd;
      logic [4:0] r = 0;
      logic [1:0] s = 0;
      logic er = 0;
      int t = 1; // R1 non-consumer
      if (i < plen && pk[i].vec && pk[i].st && pk[i].nw) begin
        e.cons[i] = 1;
        rem = int'(pk[i].nf[2:1]);
        fnd = -1;
        for (int j = i - 1; j >= 0; j--) begin
          if (pk[j].vec && rem > 0 && fnd < 0) begin
            rem--;
            if (rem == 0) fnd = j;
          end
        end
        if (pk[i].nf[2:1] == 0 || fnd < 0) begin er = 1; t = 7; end
        else if (pk[fnd].hd) begin
          r = pk[fnd].dst ^ {4'b0, pk[i].nf[0]}; s = pk[fnd].slot; t = 4;
        end else if (pk[fnd].ga) begin
          r = {4'b0, pk[i].nf[0]}; s = pk[fnd].slot; t = 5;
        end else begin er = 1; t = 6; end
      end
      e.rg[i*5 +: 5] = r;
      e.ps[i*2 +: 2] = s;
      e.err[i] = er;
      e.tag[i*4 +: 4] = 4'(t);
    end
    e.any = |e.err;
    return e;
  endfunction

  task automatic send();
    bit acc;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_vec[i] = pk[i].vec; in_store[i] = pk[i].st; in_new[i] = pk[i].nw;
      in_gather[i] = pk[i].ga; in_hasdst[i] = pk[i].hd;
      in_nfld[i*3 +: 3] = pk[i].nf; in_dst[i*5 +: 5] = pk[i].dst;
      in_slot[i*2 +: 2] = pk[i].slot;
    end
    in_len = 3'(plen);
    in_valid = 1;
    q.push_back(model());
    do begin
      #1 acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 0;
  endtask

  function automatic ins_t mk(bit v, bit s, bit n, bit g, bit h,
                              logic [2:0] nf, logic [4:0] d, logic [1:0] sl);
    ins_t x;
    x.vec = v; x.st = s; x.nw = n; x.ga = g; x.hd = h;
    x.nf = nf; x.dst = d; x.slot = sl;
    return x;
  endfunction

  // Back-pressure source
  always @(negedge clk) out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;

  // Monitor / scoreboard
  bit held = 0;
  logic [19:0] h_reg; logic [7:0] h_ps; logic [3:0] h_err;
  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (held) begin // R10 hold under stall
        chk(out_valid && out_reg == h_reg && out_pslot == h_ps && out_err == h_err,
            10, int'(out_reg), int'(h_reg));
      end
      if (out_valid && out_ready) begin
        exp_t e;
        if (q.size() == 0) chk(0, 10, 1, 0);
        else begin
          e = q.pop_front();
          for (int i = 0; i < 4; i++) begin
            int t = int'(e.tag[i*4 +: 4]);
            chk(out_cons[i] == e.cons[i], 1, out_cons[i], e.cons[i]);
            chk(out_reg[i*5 +: 5] == e.rg[i*5 +: 5], t,
                int'(out_reg[i*5 +: 5]), int'(e.rg[i*5 +: 5]));
            chk(out_pslot[i*2 +: 2] == e.ps[i*2 +: 2], e.err[i] ? 9 : 8,
                int'(out_pslot[i*2 +: 2]), int'(e.ps[i*2 +: 2]));
            chk(out_err[i] == e.err[i], t, out_err[i], e.err[i]);
          end
          chk(out_any_err == e.any, 11, out_any_err, e.any);
        end
      end
      held = out_valid && !out_ready;
      h_reg = out_reg; h_ps = out_pslot; h_err = out_err;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R12 reset state
    chk(out_valid == 0, 12, out_valid, 0);
    chk(in_ready == 1, 12, in_ready, 1);
    rst_n = 1;

    // R1 flags missing on each store; R2 field layout used throughout
    plen = 4;
    pk[0] = mk(1,0,0,0,1,3'b000,5'd3,2'd0);
    pk[1] = mk(1,1,0,0,1,3'b011,5'd4,2'd1);
    pk[2] = mk(0,1,1,0,0,3'b011,5'd5,2'd2);
    pk[3] = mk(1,0,1,0,1,3'b011,5'd6,2'd3);
    send();
    // R4 with a scalar skipped (R3), pair select 1
    plen = 3;
    pk[0] = mk(1,0,0,0,1,3'b000,5'd6,2'd3);
    pk[1] = mk(0,0,0,0,1,3'b000,5'd9,2'd0);
    pk[2] = mk(1,1,1,0,0,3'b011,5'd0,2'd1);
    send();
    // R3 distance 2 over scalar, R8 slot from in_slot
    plen = 4;
    pk[0] = mk(1,0,0,0,1,3'b000,5'd10,2'd2);
    pk[1] = mk(1,0,0,0,1,3'b000,5'd12,2'd1);
    pk[2] = mk(0,0,0,0,0,3'b000,5'd0,2'd0);
    pk[3] = mk(1,1,1,0,0,3'b100,5'd0,2'd3);
    send();
    // R5 gather without destination
    pk[0] = mk(1,0,0,1,0,3'b000,5'd17,2'd1);
    pk[1] = mk(1,1,1,0,0,3'b011,5'd0,2'd0);
    pk[2] = mk(0,0,0,0,0,3'b000,5'd0,2'd2);
    pk[3] = mk(1,1,1,0,0,3'b100,5'd0,2'd3);
    send();
    // R6 no destination, not gather; R7 index 0 consumer
    pk[0] = mk(1,1,1,0,0,3'b011,5'd0,2'd0);
    pk[1] = mk(1,0,0,0,0,3'b000,5'd8,2'd1);
    pk[2] = mk(1,1,1,0,0,3'b010,5'd0,2'd2);
    pk[3] = mk(1,1,1,0,0,3'b001,5'd0,2'd3); // R7 distance zero
    send();
    // R7 distance overruns index 0; R1 consumer beyond in_len
    plen = 2;
    pk[0] = mk(0,0,0,0,1,3'b000,5'd1,2'd0);
    pk[1] = mk(1,1,1,0,0,3'b010,5'd0,2'd1);
    pk[2] = mk(1,0,0,0,1,3'b000,5'd2,2'd2);
    pk[3] = mk(1,1,1,0,0,3'b010,5'd0,2'd3);
    send();

    // Random packets with back-pressure (R10)
    bp_en = 1;
    for (int n = 0; n < 60; n++) begin
      plen = int'($urandom % 5);
      for (int i = 0; i < 4; i++)
        pk[i] = mk($urandom%4 != 0, $urandom%2 == 1, $urandom%2 == 1,
                   $urandom%4 == 0, $urandom%4 != 0, 3'($urandom),
                   5'($urandom), 2'($urandom));
      send();
    end
    bp_en = 0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule